// File: doc/BRIEF.md
# SDRAM Bank State and Command Legality Checker

This block watches the already-decoded command stream going to a four-bank SDRAM and keeps, for every bank, a state machine that follows the commands. Each bank also has a single down-counter that times the state it is in. Every command is judged against the state of each bank it addresses. A command that the state does not allow, or that lands inside a recovery window, is reported one cycle later as an error pulse. The pulse carries an error class and the number of the objecting bank. A rejected command changes no bank state, although running timers keep counting.

Each bank has ten states. IDLE means no row is open. OPENING is the row-to-column delay after an activate. ACTIVE means a row is open. READING and WRITING are bursts. CLOSING is the precharge recovery. MRSWAIT is the mode-load recovery. REFRESHING is auto-refresh recovery. SELFREF means self refresh. WAKING is the self-refresh exit delay. The named transitions are as follows. Activate goes from IDLE to OPENING, and OPENING becomes ACTIVE when its delay runs out. Read goes from ACTIVE to READING and write goes from ACTIVE to WRITING. A burst returns to ACTIVE when it ends, or goes to CLOSING if it carries auto-precharge. A burst-stop takes a read burst to ACTIVE. Precharge goes from ACTIVE, READING or WRITING to CLOSING, and CLOSING becomes IDLE. Refresh takes every bank from IDLE to REFRESHING, which ends in IDLE. Mode load takes every bank from IDLE to MRSWAIT, which ends in IDLE. Self-refresh entry takes every bank from IDLE to SELFREF. Self-refresh exit goes from SELFREF to WAKING, which ends in IDLE.

Every delay and the burst length are parameters of at least 2 cycles. A delay of N cycles after a command at clock edge c means that a command at edge c+N is judged in the following state. A command at any earlier edge is judged in the timed state.

Top module: `sdram_bank_guard`

## Requirements
- R1: After reset every bank reads IDLE, illegal_o is 0 and err_code_o is 0. The state codes on bank_state_o (4 bits per bank, bank b at bits 4b+3..4b) are: IDLE=0, OPENING=1, ACTIVE=2, READING=3, WRITING=4, CLOSING=5, MRSWAIT=6, REFRESHING=7, SELFREF=8, WAKING=9.
- R2: Command codes on cmd_i are NOP=0, ACT=1, RD=2, WR=3, PRE=4, REF=5, SREF=6, SRX=7, MRS=8, BST=9. Codes 10 to 15 act as NOP. In IDLE, ACT moves the bank to OPENING. In IDLE, PRE is accepted and leaves the bank IDLE. In IDLE, RD, WR, BST and SRX are illegal with err_code_o=1 (state error).
- R3: OPENING lasts TRCD cycles and then becomes ACTIVE. Any non-NOP command addressed to the bank while it is OPENING is illegal with err_code_o=2 (timing error).
- R4: In ACTIVE, RD enters READING and WR enters WRITING for BURST_LEN cycles, after which the bank returns to ACTIVE. In ACTIVE, PRE enters CLOSING for TRP cycles and then IDLE. In ACTIVE, ACT, REF, SREF, MRS, BST and SRX are illegal with code 1.
- R5: During a burst without auto-precharge, PRE ends the burst and enters CLOSING. During such a burst, RD or WR starts a new full-length burst of the new kind.
- R6: BST during a read burst without auto-precharge returns the bank to ACTIVE at once. BST in any other state, writing included, is illegal with code 1.
- R7: RD or WR with a8_i=1 carries auto-precharge. BURST_LEN cycles after the command the bank enters CLOSING, and TRP cycles later it is IDLE. Any non-NOP command addressed to the bank during that burst is illegal with code 1.
- R8: PRE with a8_i=1 addresses every bank. It is accepted only if every bank is IDLE, ACTIVE or in a burst without auto-precharge. IDLE banks stay IDLE and the others enter CLOSING.
- R9: REF, SREF and MRS address every bank regardless of bank_i, and are accepted only when all banks are IDLE. REF gives REFRESHING for TRFC cycles, MRS gives MRSWAIT for TMRD cycles, and SREF gives SELFREF. All banks end in IDLE except after SREF.
- R10: In SELFREF only SRX is accepted; it addresses every bank and gives WAKING for TSREX cycles, then IDLE. Any other command is illegal with code 1.
- R11: In CLOSING, MRSWAIT, REFRESHING and WAKING any non-NOP command addressed to the bank is illegal with code 2.
- R12: A rejected command at edge c sets illegal_o=1 between edges c and c+1. In that same cycle err_code_o holds its class and err_bank_o holds the lowest-numbered objecting bank. A rejected command changes no bank state. When no command is rejected, illegal_o and err_code_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 4 | Decoded command code |
| bank_i | input | 2 | Addressed bank |
| a8_i | input | 1 | Auto-precharge on RD/WR, all-banks select on PRE |
| bank_state_o | output | 16 | Four packed 4-bit bank state codes |
| illegal_o | output | 1 | One-cycle pulse per rejected command |
| err_code_o | output | 2 | 0 none, 1 state error, 2 timing error |
| err_bank_o | output | 2 | Lowest bank that rejected the command |

## Verification
The assertions assume that cmd_i, bank_i and a8_i are stable around each rising edge and defined from reset onward. They also assume that every delay parameter is at least 2, so a timed state always lasts at least one cycle. The bench drives all inputs on the falling edge. Its directed phases use only the listed codes, and its pseudo-random phase also sends the codes 10 to 15 to exercise the NOP handling. The pseudo-random phase mixes every command with every bank and both a8_i values, so commands fall inside each recovery window and hit every state.

// File: rtl/sbg_pkg.sv
package sbg_pkg;

    localparam int ST_W = 4;

    typedef enum logic [3:0] {
        CMD_NOP  = 4'd0,
        CMD_ACT  = 4'd1,
        CMD_RD   = 4'd2,
        CMD_WR   = 4'd3,
        CMD_PRE  = 4'd4,
        CMD_REF  = 4'd5,
        CMD_SREF = 4'd6,
        CMD_SRX  = 4'd7,
        CMD_MRS  = 4'd8,
        CMD_BST  = 4'd9
    } cmd_e;

    typedef enum logic [ST_W-1:0] {
        ST_IDLE    = 4'd0,
        ST_OPENING = 4'd1,
        ST_ACTIVE  = 4'd2,
        ST_READING = 4'd3,
        ST_WRITING = 4'd4,
        ST_CLOSING = 4'd5,
        ST_MRSWAIT = 4'd6,
        ST_REFRESH = 4'd7,
        ST_SELFREF = 4'd8,
        ST_WAKING  = 4'd9
    } bank_st_e;

    typedef enum logic [1:0] {
        ERR_NONE   = 2'd0,
        ERR_STATE  = 2'd1,
        ERR_TIMING = 2'd2
    } err_e;

    function automatic cmd_e cmd_decode(logic [3:0] raw);
        return (raw <= 4'd9) ? cmd_e'(raw) : CMD_NOP;
    endfunction

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sbg_bank.sv
module sbg_bank
    import sbg_pkg::*;
#(
    parameter int TRCD      = 3,
    parameter int TRP       = 3,
    parameter int TMRD      = 2,
    parameter int TRFC      = 6,
    parameter int TSREX     = 8,
    parameter int BURST_LEN = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sel_i,
    input  cmd_e     cmd_i,
    input  logic     ap_i,
    input  logic     commit_i,
    output logic     viol_o,
    output err_e     vcode_o,
    output bank_st_e state_o
);
    localparam int MAXD = max2(max2(max2(TRCD, TRP), max2(TMRD, TRFC)), max2(TSREX, BURST_LEN));
    localparam int CW   = $clog2(MAXD + 1);
    localparam logic [CW-1:0] L_RCD  = CW'(TRCD - 1);
    localparam logic [CW-1:0] L_RP   = CW'(TRP - 1);
    localparam logic [CW-1:0] L_RPA  = CW'(TRP);
    localparam logic [CW-1:0] L_MRD  = CW'(TMRD - 1);
    localparam logic [CW-1:0] L_RFC  = CW'(TRFC - 1);
    localparam logic [CW-1:0] L_SRX  = CW'(TSREX - 1);
    localparam logic [CW-1:0] L_BL   = CW'(BURST_LEN - 1);
    localparam logic [CW-1:0] ONE    = CW'(1);

    bank_st_e        st_q, st_d;
    logic [CW-1:0]   cnt_q, cnt_d;
    logic            ap_q, ap_d;
    cmd_e            cmd_eff;
    err_e            vcode;
    logic            apply;

    // legality of the addressed command in the present state
    always_comb begin
        cmd_eff = sel_i ? cmd_i : CMD_NOP;
        vcode   = ERR_NONE;
        if (cmd_eff != CMD_NOP) begin
            unique case (st_q)
                ST_IDLE:
                    if (!(cmd_eff inside {CMD_ACT, CMD_PRE, CMD_REF, CMD_SREF, CMD_MRS}))
                        vcode = ERR_STATE;
                ST_ACTIVE:
                    if (!(cmd_eff inside {CMD_RD, CMD_WR, CMD_PRE}))
                        vcode = ERR_STATE;
                ST_READING:
                    if (ap_q || !(cmd_eff inside {CMD_RD, CMD_WR, CMD_PRE, CMD_BST}))
                        vcode = ERR_STATE;
                ST_WRITING:
                    if (ap_q || !(cmd_eff inside {CMD_RD, CMD_WR, CMD_PRE}))
                        vcode = ERR_STATE;
                ST_SELFREF:
                    if (cmd_eff != CMD_SRX)
                        vcode = ERR_STATE;
                ST_OPENING, ST_CLOSING, ST_MRSWAIT, ST_REFRESH, ST_WAKING:
                    vcode = ERR_TIMING;
                default:
                    vcode = ERR_STATE;
            endcase
        end
    end

    assign apply = commit_i && (cmd_eff != CMD_NOP);

    // next state: accepted commands first, otherwise timed exits
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        ap_d  = ap_q;
        if (apply) begin
            unique case (cmd_eff)
                CMD_ACT:  begin st_d = ST_OPENING; cnt_d = L_RCD; end
                CMD_RD:   begin st_d = ST_READING; cnt_d = L_BL; ap_d = ap_i; end
                CMD_WR:   begin st_d = ST_WRITING; cnt_d = L_BL; ap_d = ap_i; end
                CMD_PRE:  if (st_q != ST_IDLE) begin st_d = ST_CLOSING; cnt_d = L_RP; ap_d = 1'b0; end
                CMD_REF:  begin st_d = ST_REFRESH; cnt_d = L_RFC; end
                CMD_MRS:  begin st_d = ST_MRSWAIT; cnt_d = L_MRD; end
                CMD_SREF: st_d = ST_SELFREF;
                CMD_SRX:  begin st_d = ST_WAKING; cnt_d = L_SRX; end
                CMD_BST:  st_d = ST_ACTIVE;
                default:  st_d = st_q;
            endcase
        end else if (st_q inside {ST_OPENING, ST_READING, ST_WRITING, ST_CLOSING,
                                  ST_MRSWAIT, ST_REFRESH, ST_WAKING}) begin
            if (cnt_q == ONE) begin
                unique case (st_q)
                    ST_OPENING: st_d = ST_ACTIVE;
                    ST_READING, ST_WRITING:
                        if (ap_q) begin
                            st_d  = ST_CLOSING;
                            cnt_d = L_RPA;
                            ap_d  = 1'b0;
                        end else begin
                            st_d = ST_ACTIVE;
                        end
                    default: st_d = ST_IDLE;
                endcase
            end else begin
                cnt_d = cnt_q - ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
            ap_q  <= 1'b0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            ap_q  <= ap_d;
        end
    end

    always_comb begin
        state_o = st_q;
        vcode_o = vcode;
        viol_o  = (vcode != ERR_NONE);
    end

    // R3: the row-open window can only end in ACTIVE
    assert_opening_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_OPENING) |=> (st_q == ST_OPENING || st_q == ST_ACTIVE));

    // R7: an auto-precharge read burst can only proceed to precharge
    assert_autopre_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_READING && ap_q) |=> (st_q == ST_READING || st_q == ST_CLOSING));

    // R9: mode-load recovery leaves only to IDLE
    assert_mrs_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_MRSWAIT) |=> (st_q == ST_MRSWAIT || st_q == ST_IDLE));

    // R10: self refresh is left only through the exit delay
    assert_selfref_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SELFREF) |=> (st_q == ST_SELFREF || st_q == ST_WAKING));

    // R11: refresh recovery leaves only to IDLE
    assert_refresh_exit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_REFRESH) |=> (st_q == ST_REFRESH || st_q == ST_IDLE));

    // R12: a rejected command leaves an untimed state untouched
    assert_hold_on_error_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_o && (st_q == ST_IDLE || st_q == ST_ACTIVE || st_q == ST_SELFREF))
        |=> $stable(st_q));

endmodule

// File: rtl/sbg_err_pick.sv
module sbg_err_pick #(
    parameter int NUM_BANKS = 4,
    localparam int BW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic [NUM_BANKS-1:0]   viol_i,
    input  logic [2*NUM_BANKS-1:0] code_i,
    output logic                   any_o,
    output logic [BW-1:0]          idx_o,
    output logic [1:0]             code_o
);
    always_comb begin
        any_o  = 1'b0;
        idx_o  = '0;
        code_o = 2'd0;
        for (int b = NUM_BANKS - 1; b >= 0; b--) begin
            if (viol_i[b]) begin
                any_o  = 1'b1;
                idx_o  = BW'(b);
                code_o = code_i[2*b +: 2];
            end
        end
    end
endmodule

// File: rtl/sdram_bank_guard.sv
module sdram_bank_guard
    import sbg_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int TRCD      = 3,
    parameter int TRP       = 3,
    parameter int TMRD      = 2,
    parameter int TRFC      = 6,
    parameter int TSREX     = 8,
    parameter int BURST_LEN = 4,
    localparam int BW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [3:0]                cmd_i,
    input  logic [BW-1:0]             bank_i,
    input  logic                      a8_i,
    output logic [NUM_BANKS*ST_W-1:0] bank_state_o,
    output logic                      illegal_o,
    output logic [1:0]                err_code_o,
    output logic [BW-1:0]             err_bank_o
);
    cmd_e                   cmd;
    logic                   all_banks;
    logic [NUM_BANKS-1:0]   viol;
    logic [2*NUM_BANKS-1:0] codes;
    logic                   any_viol;
    logic [BW-1:0]          pick_bank;
    logic [1:0]             pick_code;
    logic                   illegal_q;
    logic [1:0]             code_q;
    logic [BW-1:0]          bank_q;

    assign cmd       = cmd_decode(cmd_i);
    assign all_banks = (cmd inside {CMD_REF, CMD_SREF, CMD_SRX, CMD_MRS}) ||
                       (cmd == CMD_PRE && a8_i);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        bank_st_e st;
        err_e     vc;
        sbg_bank #(
            .TRCD(TRCD), .TRP(TRP), .TMRD(TMRD), .TRFC(TRFC),
            .TSREX(TSREX), .BURST_LEN(BURST_LEN)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .sel_i    (all_banks || (bank_i == BW'(b))),
            .cmd_i    (cmd),
            .ap_i     (a8_i),
            .commit_i (!any_viol),
            .viol_o   (viol[b]),
            .vcode_o  (vc),
            .state_o  (st)
        );
        assign codes[2*b +: 2]           = vc;
        assign bank_state_o[b*ST_W +: ST_W] = st;
    end

    sbg_err_pick #(.NUM_BANKS(NUM_BANKS)) u_pick (
        .viol_i (viol),
        .code_i (codes),
        .any_o  (any_viol),
        .idx_o  (pick_bank),
        .code_o (pick_code)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            illegal_q <= 1'b0;
            code_q    <= 2'd0;
            bank_q    <= '0;
        end else begin
            illegal_q <= any_viol;
            code_q    <= pick_code;
            bank_q    <= pick_bank;
        end
    end

    assign illegal_o  = illegal_q;
    assign err_code_o = code_q;
    assign err_bank_o = bank_q;

    // R12: a pulse always carries a class, and no class appears without a pulse
    assert_pulse_has_code_R12: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (err_code_o != 2'd0));
    assert_quiet_no_code_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !illegal_o |-> (err_code_o == 2'd0));

endmodule

// File: tb/sim_sdram_bank_guard.sv
module sim_sdram_bank_guard;
    localparam int CLK_PERIOD = 10;
    localparam int NB    = 4;
    localparam int TRCD  = 3;
    localparam int TRP   = 3;
    localparam int TMRD  = 2;
    localparam int TRFC  = 6;
    localparam int TSREX = 8;
    localparam int BL    = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cmd = 4'd0;
    logic [1:0]  bank = 2'd0;
    logic        a8 = 1'b0;
    logic [15:0] bstate;
    logic        illegal;
    logic [1:0]  ecode;
    logic [1:0]  ebank;

    sdram_bank_guard #(
        .NUM_BANKS(NB), .TRCD(TRCD), .TRP(TRP), .TMRD(TMRD),
        .TRFC(TRFC), .TSREX(TSREX), .BURST_LEN(BL)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .bank_i(bank), .a8_i(a8),
        .bank_state_o(bstate), .illegal_o(illegal), .err_code_o(ecode), .err_bank_o(ebank)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int m_st[NB];
    int m_dl[NB];
    bit m_ap[NB];
    int now_edge;
    int exp_ill, exp_code, exp_bank;
    int checks = 0;
    int fails = 0;
    bit done = 0;

    function automatic int judge(int st, bit ap, int c);
        if (c == 0) return 0;
        if (st == 1 || st == 5 || st == 6 || st == 7 || st == 9) return 2;
        if (st == 0) return (c == 1 || c == 4 || c == 5 || c == 6 || c == 8) ? 0 : 1;
        if (st == 2) return (c == 2 || c == 3 || c == 4) ? 0 : 1;
        if (st == 3) return (!ap && (c == 2 || c == 3 || c == 4 || c == 9)) ? 0 : 1;
        if (st == 4) return (!ap && (c == 2 || c == 3 || c == 4)) ? 0 : 1;
        if (st == 8) return (c == 7) ? 0 : 1;
        return 1;
    endfunction

    task automatic model_edge(int c_raw, int b, bit a);
        int c;
        bit hit[NB];
        bit bad;
        c = (c_raw > 9) ? 0 : c_raw;
        now_edge++;
        for (int k = 0; k < NB; k++)
            hit[k] = (c == 5 || c == 6 || c == 7 || c == 8 || (c == 4 && a)) ? 1'b1 : (k == b);
        bad = 0; exp_ill = 0; exp_code = 0; exp_bank = 0;
        for (int k = 0; k < NB; k++) begin
            if (hit[k] && !bad && judge(m_st[k], m_ap[k], c) != 0) begin
                bad = 1;
                exp_ill = 1;
                exp_code = judge(m_st[k], m_ap[k], c);
                exp_bank = k;
            end
        end
        for (int k = 0; k < NB; k++) begin
            if (hit[k] && !bad && c != 0) begin
                case (c)
                    1: begin m_st[k] = 1; m_dl[k] = now_edge + TRCD; end
                    2: begin m_st[k] = 3; m_dl[k] = now_edge + BL; m_ap[k] = a; end
                    3: begin m_st[k] = 4; m_dl[k] = now_edge + BL; m_ap[k] = a; end
                    4: if (m_st[k] != 0) begin m_st[k] = 5; m_dl[k] = now_edge + TRP; m_ap[k] = 0; end
                    5: begin m_st[k] = 7; m_dl[k] = now_edge + TRFC; end
                    6: m_st[k] = 8;
                    7: begin m_st[k] = 9; m_dl[k] = now_edge + TSREX; end
                    8: begin m_st[k] = 6; m_dl[k] = now_edge + TMRD; end
                    9: m_st[k] = 2;
                    default: ;
                endcase
            end else if (m_st[k] != 0 && m_st[k] != 2 && m_st[k] != 8 && now_edge + 1 == m_dl[k]) begin
                if (m_st[k] == 1) m_st[k] = 2;
                else if (m_st[k] == 3 || m_st[k] == 4) begin
                    if (m_ap[k]) begin
                        m_st[k] = 5; m_dl[k] = now_edge + 1 + TRP; m_ap[k] = 0;
                    end else m_st[k] = 2;
                end else m_st[k] = 0;
            end
        end
    endtask

    task automatic cmp(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s at edge %0d: actual=%0d expected=%0d", tag, what, now_edge, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        for (int k = 0; k < NB; k++)
            cmp(tag, $sformatf("bank%0d state", k), int'(bstate[4*k +: 4]), m_st[k]);
        cmp(tag, "illegal", int'(illegal), exp_ill);
        cmp(tag, "err_code", int'(ecode), exp_code);
        if (exp_ill != 0) cmp(tag, "err_bank", int'(ebank), exp_bank);
    endtask

    task automatic issue(int c, int b, bit a, string tag);
        cmd = 4'(c); bank = 2'(b); a8 = a;
        @(posedge clk);
        model_edge(c, b, a);
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) issue(0, 0, 0, tag);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL R12 watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        for (int k = 0; k < NB; k++) begin m_st[k] = 0; m_dl[k] = 0; m_ap[k] = 0; end
        now_edge = 0; exp_ill = 0; exp_code = 0; exp_bank = 0;
        repeat (3) @(negedge clk);
        check_all("R1");
        rst_n = 1'b1;

        // R2: idle-state table
        issue(2, 0, 0, "R2");
        issue(4, 0, 0, "R2");
        issue(9, 1, 0, "R2");
        issue(7, 2, 0, "R2");
        issue(1, 0, 0, "R2");
        // R3: commands inside the row-open window
        issue(2, 0, 0, "R3");
        issue(4, 0, 0, "R3");
        idle(2, "R3");
        // R4: burst and precharge from ACTIVE
        issue(2, 0, 0, "R4");
        idle(4, "R4");
        issue(1, 0, 0, "R4");
        issue(3, 0, 0, "R4");
        idle(4, "R4");
        issue(4, 0, 0, "R4");
        idle(3, "R4");
        // R5: termination and restart
        issue(1, 1, 0, "R5");
        idle(3, "R5");
        issue(2, 1, 0, "R5");
        issue(3, 1, 0, "R5");
        issue(2, 1, 0, "R5");
        issue(4, 1, 0, "R5");
        idle(3, "R5");
        // R6: burst stop
        issue(1, 2, 0, "R6");
        idle(3, "R6");
        issue(2, 2, 0, "R6");
        issue(9, 2, 0, "R6");
        issue(3, 2, 0, "R6");
        issue(9, 2, 0, "R6");
        issue(9, 2, 0, "R6");
        idle(4, "R6");
        // R7: auto-precharge
        issue(2, 2, 1, "R7");
        issue(4, 2, 0, "R7");
        issue(2, 2, 0, "R7");
        idle(8, "R7");
        // R8: precharge of all banks
        issue(1, 3, 0, "R8");
        issue(1, 1, 0, "R8");
        issue(4, 0, 1, "R8");
        idle(3, "R8");
        issue(2, 3, 0, "R8");
        issue(4, 2, 1, "R8");
        idle(4, "R8");
        // R9: device-wide commands
        issue(1, 0, 0, "R9");
        issue(5, 2, 0, "R9");
        idle(3, "R9");
        issue(4, 0, 1, "R9");
        idle(3, "R9");
        issue(5, 1, 0, "R9");
        // R11: refresh window
        issue(1, 3, 0, "R11");
        idle(6, "R11");
        issue(8, 0, 0, "R9");
        issue(8, 0, 0, "R11");
        idle(2, "R9");
        // R10: self refresh
        issue(6, 0, 0, "R10");
        issue(1, 2, 0, "R10");
        issue(7, 1, 0, "R10");
        issue(1, 0, 0, "R11");
        idle(9, "R10");
        // R12: unknown codes ignored, lowest bank reported
        issue(12, 1, 0, "R12");
        issue(15, 0, 1, "R12");
        issue(1, 2, 0, "R12");
        issue(1, 3, 0, "R12");
        issue(5, 0, 0, "R12");
        idle(4, "R12");

        lfsr = 16'hACE1;
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            issue(int'(lfsr[3:0]), int'(lfsr[5:4]), lfsr[6] & lfsr[7], "R12");
        end

        done = 1;
        summary();
        $finish;
    end
endmodule